// File: doc/BRIEF.md
# Audio Serial Transmit Frame Engine

This block sends audio words out one bit per bit clock, grouped into frames. It takes words through a small transmit queue. It either produces the frame sync itself (master) or follows a frame sync that arrives from outside (slave). A frame holds a programmable number of words. The first word of each frame has its own width setting, and every later word in the frame shares a second width setting. Each width field holds the word length minus one. Word lengths under 8 bits are outside the supported range, except for the first word of a frame that carries more than one word. Configuration inputs are held steady while `tx_en` is high.

The controller is a three-state machine:
- `ST_OFF` (disabled) moves to `ST_WAIT` when `tx_en` rises.
- `ST_WAIT` moves to `ST_SHIFT` when a frame may start. In master mode a frame may start unless gating is enabled and the queue warning flag is set. In slave mode a frame starts on a detected active edge of `fs_in`.
- `ST_SHIFT` shifts bits out MSB first. At the last bit of a word it loads the next word of the frame. At the last bit of the frame it either starts the next frame at once (the start condition holds) or falls back to `ST_WAIT`.
- Any state returns to `ST_OFF` when `tx_en` drops.

If the queue is empty when a word is due, zeros are sent and a sticky underrun flag is raised.

Top module: `atx_frame_engine`

## Requirements
- R1: The transmit queue holds DEPTH words. `fifo_full` is 1 when it holds DEPTH words. A push while full is dropped and never transmitted.
- R2: `fifo_warn` is 1 exactly when the queue occupancy is at or below `cfg_watermark`, which includes an empty queue.
- R3: Words go out MSB first, one bit per bit clock. Word 0 of a frame carries `cfg_first_wid`+1 bits, and every later word carries `cfg_next_wid`+1 bits. A frame carries `cfg_words_m1`+1 words. Bit i of a word of width field w is sent as bit position w−i of the pushed data.
- R4: The frame sync is active during exactly the first bit clock of word 0. It is active high when `cfg_fs_active_low`=0 and active low when it is 1. The inactive level is the inverse.
- R5: With `cfg_fs_master`=1, `fs_oe`=1 while enabled, and frames with no gating repeat back to back. The next frame sync follows the last bit of the previous frame. With `cfg_fs_master`=0, `fs_oe`=0.
- R6: In master mode with `cfg_fs_gate`=1, no frame starts while `fifo_warn` is 1. A frame starts within two bit clocks once the flag clears.
- R7: In slave mode, an active edge on `fs_in` makes the first bit of word 0 appear in the next bit clock. An edge seen during the last bit of a frame starts the next frame with no gap.
- R8: In slave mode, `fs_in` edges during a frame (other than its last bit) are ignored. After a frame ends without an edge, `sd_out` stays 0 until the next edge.
- R9: When a word is due and the queue is empty, the word is sent as zeros and `underrun` is set. It stays set until `underrun_clr` is pulsed.
- R10: While `tx_en` is 0, `sd_out` is 0 and `fs_out` sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| tx_en | input | 1 | Transmit enable |
| cfg_fs_master | input | 1 | 1: frame sync generated here, 0: received |
| cfg_fs_active_low | input | 1 | Frame sync polarity, 1 = active low |
| cfg_fs_gate | input | 1 | Hold off internal frame sync while warning is set |
| cfg_first_wid | input | BW | Bits in word 0 minus one |
| cfg_next_wid | input | BW | Bits in later words minus one |
| cfg_words_m1 | input | WCW | Words per frame minus one |
| cfg_watermark | input | CW | Warning threshold on queue occupancy |
| push_valid | input | 1 | Push a word into the queue |
| push_data | input | DW | Word to push |
| fifo_full | output | 1 | Queue full |
| fifo_warn | output | 1 | Occupancy at or below watermark |
| fs_in | input | 1 | External frame sync |
| fs_out | output | 1 | Frame sync driven in master mode |
| fs_oe | output | 1 | Frame sync output enable |
| sd_out | output | 1 | Serial data |
| underrun | output | 1 | Sticky underrun flag |
| underrun_clr | input | 1 | Clears the underrun flag |

## Verification
The bench uses the default build: 32-bit words, a four-entry queue and a 4-bit words-per-frame field. With those sizes it can fill the queue completely and watch it drain into underrun. It sweeps both polarities, one to three words per frame, and three widths each for the first word and the later words. Every bit of each frame is compared against data computed in the bench. Separate runs cover slave framing, with edges at frame start, at the last bit and mid-frame, and master gating around a watermark of one.

// File: rtl/atx_pkg.sv
package atx_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } atx_state_e;
endpackage

// File: rtl/atx_fifo.sv
module atx_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic [CW-1:0] watermark,
    output logic [DW-1:0] pop_data,
    output logic          full,
    output logic          empty,
    output logic          warn
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign warn     = (count <= watermark);
    assign do_push  = push_valid && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    a_r1_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    a_r1_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_valid && !pop) |=> (full && count == $past(count)));
endmodule

// File: rtl/atx_fsync.sv
module atx_fsync (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic cfg_master,
    input  logic cfg_active_low,
    input  logic cfg_gate,
    input  logic warn,
    input  logic fs_in,
    input  logic fs_int,
    output logic start_ok,
    output logic fs_out,
    output logic fs_oe
);
    logic fs_act, fs_act_q, fs_edge;

    assign fs_act  = fs_in ^ cfg_active_low;
    assign fs_edge = fs_act && !fs_act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_act_q <= 1'b0;
        else        fs_act_q <= fs_act;
    end

    always_comb begin
        if (cfg_master) begin
            start_ok = !(cfg_gate && warn);
            fs_out   = fs_int ^ cfg_active_low;
        end else begin
            start_ok = fs_edge;
            fs_out   = cfg_active_low;
        end
        fs_oe = cfg_master && tx_en;
    end
endmodule

// File: rtl/atx_fsm.sv
module atx_fsm
    import atx_pkg::*;
#(
    parameter int DW  = 32,
    parameter int WCW = 4,
    localparam int BW = $clog2(DW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tx_en,
    input  logic           start_ok,
    input  logic [BW-1:0]  cfg_first_wid,
    input  logic [BW-1:0]  cfg_next_wid,
    input  logic [WCW-1:0] cfg_words_m1,
    input  logic           fifo_empty,
    input  logic [DW-1:0]  fifo_data,
    input  logic           underrun_clr,
    output logic           pop,
    output logic           sd_out,
    output logic           fs_int,
    output logic           underrun
);
    atx_state_e    state, state_nx;
    logic [DW-1:0] sreg;
    logic [BW-1:0] bitcnt;
    logic [WCW-1:0] wordcnt;
    logic          fs_q;
    logic          load, load_first;
    logic [BW-1:0] wid_sel;
    logic [DW-1:0] src;

    // next-state and load decision
    always_comb begin
        state_nx   = state;
        load       = 1'b0;
        load_first = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (tx_en) state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (!tx_en) state_nx = ST_OFF;
                else if (start_ok) begin
                    state_nx   = ST_SHIFT;
                    load       = 1'b1;
                    load_first = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (!tx_en) state_nx = ST_OFF;
                else if (bitcnt == '0) begin
                    if (wordcnt != cfg_words_m1) begin
                        load = 1'b1;
                    end else if (start_ok) begin
                        load       = 1'b1;
                        load_first = 1'b1;
                    end else begin
                        state_nx = ST_WAIT;
                    end
                end
            end
            default: state_nx = ST_OFF;
        endcase
    end

    assign pop     = load && !fifo_empty;
    assign wid_sel = load_first ? cfg_first_wid : cfg_next_wid;
    assign src     = fifo_empty ? '0 : fifo_data;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg     <= '0;
            bitcnt   <= '0;
            wordcnt  <= '0;
            fs_q     <= 1'b0;
            underrun <= 1'b0;
        end else begin
            if (load) begin
                sreg    <= src << (BW'(DW - 1) - wid_sel);
                bitcnt  <= wid_sel;
                wordcnt <= load_first ? '0 : wordcnt + 1'b1;
                fs_q    <= load_first;
            end else if (state == ST_SHIFT) begin
                sreg   <= sreg << 1;
                bitcnt <= bitcnt - 1'b1;
                fs_q   <= 1'b0;
            end else begin
                fs_q <= 1'b0;
            end
            if (load && fifo_empty) underrun <= 1'b1;
            else if (underrun_clr)  underrun <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        sd_out = 1'b0;
        fs_int = 1'b0;
        if (state == ST_SHIFT) begin
            sd_out = sreg[DW-1];
            fs_int = fs_q;
        end
    end

    a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && tx_en && bitcnt != '0)
        |=> (state == ST_SHIFT && bitcnt == BW'($past(bitcnt) - 1'b1)));

    a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!sd_out && !fs_int));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !underrun_clr) |=> underrun);

    a_r4_fs_single: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_int && cfg_first_wid != '0) |=> !fs_int);
endmodule

// File: rtl/atx_frame_engine.sv
module atx_frame_engine #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int WCW   = 4,
    localparam int BW   = $clog2(DW),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           bclk,
    input  logic           rst_n,
    input  logic           tx_en,
    input  logic           cfg_fs_master,
    input  logic           cfg_fs_active_low,
    input  logic           cfg_fs_gate,
    input  logic [BW-1:0]  cfg_first_wid,
    input  logic [BW-1:0]  cfg_next_wid,
    input  logic [WCW-1:0] cfg_words_m1,
    input  logic [CW-1:0]  cfg_watermark,
    input  logic           push_valid,
    input  logic [DW-1:0]  push_data,
    output logic           fifo_full,
    output logic           fifo_warn,
    input  logic           fs_in,
    output logic           fs_out,
    output logic           fs_oe,
    output logic           sd_out,
    output logic           underrun,
    input  logic           underrun_clr
);
    logic          pop, empty, start_ok, fs_int;
    logic [DW-1:0] pop_data;

    atx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(bclk), .rst_n(rst_n),
        .push_valid(push_valid), .push_data(push_data),
        .pop(pop), .watermark(cfg_watermark),
        .pop_data(pop_data), .full(fifo_full), .empty(empty), .warn(fifo_warn)
    );

    atx_fsync u_fsync (
        .clk(bclk), .rst_n(rst_n), .tx_en(tx_en),
        .cfg_master(cfg_fs_master), .cfg_active_low(cfg_fs_active_low),
        .cfg_gate(cfg_fs_gate), .warn(fifo_warn), .fs_in(fs_in),
        .fs_int(fs_int), .start_ok(start_ok), .fs_out(fs_out), .fs_oe(fs_oe)
    );

    atx_fsm #(.DW(DW), .WCW(WCW)) u_fsm (
        .clk(bclk), .rst_n(rst_n), .tx_en(tx_en), .start_ok(start_ok),
        .cfg_first_wid(cfg_first_wid), .cfg_next_wid(cfg_next_wid),
        .cfg_words_m1(cfg_words_m1), .fifo_empty(empty), .fifo_data(pop_data),
        .underrun_clr(underrun_clr), .pop(pop), .sd_out(sd_out),
        .fs_int(fs_int), .underrun(underrun)
    );

    a_r6_gate_hold: assert property (@(posedge bclk) disable iff (!rst_n)
        (cfg_fs_master && cfg_fs_gate && fifo_warn) |=> !fs_int);
endmodule

// File: tb/sim_atx_frame_engine.sv
module sim_atx_frame_engine;
    localparam int CLK_PERIOD = 10;

    logic bclk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, cfg_fs_master = 1'b1, cfg_fs_active_low = 1'b0, cfg_fs_gate = 1'b0;
    logic [4:0] cfg_first_wid = 5'd15, cfg_next_wid = 5'd15;
    logic [3:0] cfg_words_m1 = 4'd0;
    logic [2:0] cfg_watermark = 3'd1;
    logic push_valid = 1'b0;
    logic [31:0] push_data = '0;
    logic fs_in = 1'b0, underrun_clr = 1'b0;
    logic fifo_full, fifo_warn, fs_out, fs_oe, sd_out, underrun;

    int nchk = 0, nfail = 0;

    atx_frame_engine u0 (.*);

    always #(CLK_PERIOD/2) bclk = ~bclk;

    function automatic logic [31:0] wd(input int k);
        return 32'((k + 3) * 32'h9E37_79B9) ^ 32'h5A5A_C3C3;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] d);
        push_valid = 1'b1;
        push_data  = d;
        @(negedge bclk);
        push_valid = 1'b0;
    endtask

    task automatic pulse_fs(input logic pol);
        fs_in = ~pol;
        @(negedge bclk);
        fs_in = pol;
    endtask

    // checks one frame starting at the current negedge (first bit of word 0)
    task automatic check_frame(input int k0, input bit zero, input int w0, input int wn,
                               input int nm1, input logic pol, input bit master, input int pulse_at);
        int p = 0;
        for (int k = 0; k <= nm1; k++) begin
            for (int b = 0; b <= ((k == 0) ? w0 : wn); b++) begin
                automatic int wf = (k == 0) ? w0 : wn;
                automatic logic [31:0] d = zero ? 32'h0 : wd(k0 + k);
                automatic logic eb = d[wf - b];
                automatic logic ef = ((k == 0 && b == 0) ? 1'b1 : 1'b0) ^ pol;
                chk(sd_out == eb, zero ? "R9 zero data" : "R3 serial bit", sd_out, eb);
                if (master) chk(fs_out == ef, "R4 frame sync", fs_out, ef);
                fs_in = (p == pulse_at) ? ~pol : pol;
                p++;
                @(negedge bclk);
            end
        end
        fs_in = pol;
    endtask

    task automatic wait_fs(input logic pol, input int lim, output bit found);
        found = 1'b0;
        for (int t = 0; t < lim; t++) begin
            if (fs_out == ~pol) begin
                found = 1'b1;
                break;
            end
            @(negedge bclk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        bit found;
        repeat (3) @(negedge bclk);
        rst_n = 1'b1;
        @(negedge bclk);
        chk(sd_out == 1'b0, "R10 reset sd", sd_out, 0);
        chk(fs_out == 1'b0, "R10 reset fs", fs_out, 0);
        chk(underrun == 1'b0, "R9 reset underrun", underrun, 0);
        chk(fifo_warn == 1'b1, "R2 reset warn", fifo_warn, 1);
        chk(fifo_full == 1'b0, "R1 reset full", fifo_full, 0);

        // master sweep, no gating
        for (int pol = 0; pol < 2; pol++)
        for (int nm1 = 0; nm1 < 3; nm1++)
        for (int i0 = 0; i0 < 3; i0++)
        for (int in = 0; in < 3; in++) begin
            automatic int w0 = (i0 == 0) ? 7 : (i0 == 1) ? 12 : 31;
            automatic int wn = (in == 0) ? 7 : (in == 1) ? 15 : 23;
            tx_en = 1'b0;
            cfg_fs_master = 1'b1;
            cfg_fs_gate = 1'b0;
            cfg_fs_active_low = pol[0];
            fs_in = pol[0];
            cfg_first_wid = 5'(w0);
            cfg_next_wid = 5'(wn);
            cfg_words_m1 = 4'(nm1);
            cfg_watermark = 3'd1;
            @(negedge bclk);
            chk(fs_out == pol[0], "R10 idle fs level", fs_out, pol[0]);
            for (int i = 0; i <= nm1; i++) begin
                push(wd(i));
                chk(fifo_warn == (i + 1 <= 1), "R2 warn vs watermark", fifo_warn, (i + 1 <= 1));
            end
            tx_en = 1'b1;
            wait_fs(pol[0], 6, found);
            chk(found, "R5 master frame start", found, 1);
            chk(fs_oe == 1'b1, "R5 master drives fs", fs_oe, 1);
            check_frame(0, 1'b0, w0, wn, nm1, pol[0], 1'b1, -1);
            check_frame(0, 1'b1, w0, wn, nm1, pol[0], 1'b1, -1); // R5 back to back
            chk(underrun == 1'b1, "R9 underrun set", underrun, 1);
            tx_en = 1'b0;
            underrun_clr = 1'b1;
            @(negedge bclk);
            underrun_clr = 1'b0;
            chk(sd_out == 1'b0, "R10 disabled sd", sd_out, 0);
            chk(fs_out == pol[0], "R10 disabled fs", fs_out, pol[0]);
            chk(underrun == 1'b0, "R9 underrun cleared", underrun, 0);
        end

        // slave mode, active-low sync, 2 words per frame
        cfg_fs_master = 1'b0;
        cfg_fs_active_low = 1'b1;
        fs_in = 1'b1;
        cfg_first_wid = 5'd15;
        cfg_next_wid = 5'd11;
        cfg_words_m1 = 4'd1;
        cfg_watermark = 3'd0;
        @(negedge bclk);
        for (int i = 0; i < 4; i++) push(wd(10 + i));
        chk(fifo_full == 1'b1, "R1 full at depth", fifo_full, 1);
        push(32'hFFFF_FFFF); // dropped
        chk(fifo_full == 1'b1, "R1 full after drop", fifo_full, 1);
        tx_en = 1'b1;
        for (int t = 0; t < 8; t++) begin
            @(negedge bclk);
            chk(sd_out == 1'b0, "R8 slave idle", sd_out, 0);
        end
        chk(fs_oe == 1'b0, "R5 slave no drive", fs_oe, 0);
        pulse_fs(1'b1);
        check_frame(10, 1'b0, 15, 11, 1, 1'b1, 1'b0, 27);   // R7 edge at last bit
        check_frame(12, 1'b0, 15, 11, 1, 1'b1, 1'b0, 5);    // R8 mid-frame edge
        for (int t = 0; t < 10; t++) begin
            chk(sd_out == 1'b0, "R8 no restart", sd_out, 0);
            @(negedge bclk);
        end
        chk(underrun == 1'b0, "R9 no underrun yet", underrun, 0);
        pulse_fs(1'b1);
        check_frame(0, 1'b1, 15, 11, 1, 1'b1, 1'b0, -1);    // R1 dropped word absent
        chk(underrun == 1'b1, "R9 slave underrun", underrun, 1);
        tx_en = 1'b0;
        underrun_clr = 1'b1;
        @(negedge bclk);
        underrun_clr = 1'b0;

        // master gating, watermark 1
        cfg_fs_master = 1'b1;
        cfg_fs_active_low = 1'b0;
        fs_in = 1'b0;
        cfg_fs_gate = 1'b1;
        cfg_watermark = 3'd1;
        cfg_words_m1 = 4'd0;
        cfg_first_wid = 5'd15;
        tx_en = 1'b1;
        for (int t = 0; t < 20; t++) begin
            @(negedge bclk);
            chk(fs_out == 1'b0, "R6 gated while empty", fs_out, 0);
        end
        push(wd(20));
        for (int t = 0; t < 10; t++) begin
            chk(fs_out == 1'b0, "R6 gated at watermark", fs_out, 0);
            @(negedge bclk);
        end
        push(wd(21));
        wait_fs(1'b0, 3, found);
        chk(found, "R6 start after warn clears", found, 1);
        check_frame(20, 1'b0, 15, 15, 0, 1'b0, 1'b1, -1);
        for (int t = 0; t < 20; t++) begin
            chk(fs_out == 1'b0, "R6 gated again", fs_out, 0);
            chk(sd_out == 1'b0, "R6 quiet", sd_out, 0);
            @(negedge bclk);
        end
        tx_en = 1'b0;
        @(negedge bclk);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule